// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

The controller collects 64 interrupt request lines and turns them into eight request outputs: a normal interrupt line, a fast interrupt line and six auxiliary lines. Each source has a control byte that turns it on, picks how it triggers (level high, rising edge, falling edge or both edges) and picks one of the eight outputs. Edge events are caught in status bits, and software clears them by writing ones. A source counts as pending when it is enabled and either its level input is high (level mode) or its status bit is set (edge mode). Each output line is the OR of the pending sources routed to it.

For the normal and the fast line, an arbiter picks one pending source and shows its number in an identification register. The arbiter works in fixed order, where the lowest number wins. It can also work in rotating order, where the source last returned by a read of the identification register drops to the lowest priority. When nothing is pending, the identification register reads 63. Software therefore uses the status bit of source 63 to tell a real request on source 63 from the idle value.

Registers sit on a simple 32-bit bus. The bus has a word address, byte-lane write enables and read data that is valid in the same cycle as the request.

Top module: `icu_vec64`

## Requirements
- R1: After reset all outputs are low, every control byte and status bit reads 0, both identification registers read 63, and both priority registers read 0x3F (fixed order, pointer 63).
- R2: The control byte of source n is lane n%4 of word 0x10+n/4 (byte offset 0x40+n). Bits [2:0] are the destination, bit 3 is the enable, bit 5 is rising trigger and bit 6 is falling trigger. Bits 4 and 7 are stored. A write changes only the lanes whose enable bit is set, and the whole byte reads back.
- R3: An enabled source with both trigger bits clear is pending exactly while its input is high. It reaches its output in the same cycle, with no register on the path.
- R4: With bit 5 set, a rising input sets the status bit. With bit 6 set, a falling input sets it. With both bits set, either edge sets it. The bit is set at the first clock edge that sees the change, whether or not the source is enabled. Status bits for sources 0 to 31 are in word 0x20 and those for sources 32 to 63 are in word 0x21, at bit n%32.
- R5: Writing 1 to a status bit clears it, but only for a byte lane that is enabled. If an edge arrives in the same cycle as the clear, the bit stays set.
- R6: Destination 0 drives irq_o, destination 1 drives fiq_o, and destinations 2 to 7 drive aux_o[0] to aux_o[5].
- R7: A source whose enable bit is clear drives no output and never wins arbitration, even when its input is high or its status bit is set.
- R8: Word 0x00 returns the winning normal-line source in bits [5:0], and word 0x01 returns the winning fast-line source. In fixed order the lowest-numbered pending source wins. With nothing pending the value is 63.
- R9: In priority word 0x08 (normal line) and word 0x09 (fast line), bit 6 selects rotating order and bits [5:0] hold the pointer, which software can write. In rotating order the search starts at pointer+1 and wraps around. A read of the identification word that finds a pending source loads that source into the pointer.
- R10: A read of an identification word that finds nothing pending leaves the pointer unchanged. A pending source 63 also reads 63, and only status bit 31 of word 0x21 tells it apart from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt request lines |
| bus_req_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Word address (byte offset / 4) |
| bus_be_i | input | 4 | Byte-lane write enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| aux_o | output | 6 | Auxiliary request lines for destinations 2 to 7 |

## Verification
A level request reaches its output in the same cycle the input changes, because no register sits on that path. An edge shows up in status, and from there on the outputs, only after the first rising clock edge that sees it. Control, status and priority writes take effect at the clock edge that accepts them. Identification reads are combinational, and the rotation pointer moves at the clock edge that ends the read. The bench drives every input on the falling edge and samples read data 1 ns later. It samples outputs 1 ns after the rising edge that ends each step, and at that point its model has already applied the same edge.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned NUM_DEST = 8;
  localparam int unsigned ROT_BIT  = 6;
  // word addresses
  localparam int unsigned W_ID     = 'h00;
  localparam int unsigned W_PRI    = 'h08;
  localparam int unsigned W_CTRL   = 'h10;
  localparam int unsigned W_STAT   = 'h20;

  localparam logic [2:0] DST_IRQ = 3'd0;
  localparam logic [2:0] DST_FIQ = 3'd1;

  typedef struct packed {
    logic       rsv7;
    logic       trig_fall;
    logic       trig_rise;
    logic       rsv4;
    logic       enable;
    logic [2:0] dest;
  } src_ctrl_t;
endpackage

// File: rtl/icu_src.sv
module icu_src
  import icu_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      src_i,
  input  logic      ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  input  logic      clr_i,
  output src_ctrl_t ctrl_o,
  output logic      stat_o,
  output logic      pend_o
);
  src_ctrl_t ctrl_q;
  logic src_q, stat_q, edge_mode, hit;

  assign edge_mode = ctrl_q.trig_rise | ctrl_q.trig_fall;
  assign hit = (ctrl_q.trig_rise & src_i & ~src_q) |
               (ctrl_q.trig_fall & ~src_i & src_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src_q  <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      src_q  <= src_i;
      stat_q <= (stat_q & ~clr_i) | hit;  // new edge beats clear
      if (ctrl_we_i) ctrl_q <= src_ctrl_t'(ctrl_wdata_i);
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
  assign pend_o = ctrl_q.enable & (edge_mode ? stat_q : src_i);

  a_r4_rise_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o.trig_rise && src_i && !src_q) |=> stat_o);
  a_r4_fall_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o.trig_fall && !src_i && src_q) |=> stat_o);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ctrl_o.trig_rise && !ctrl_o.trig_fall) |=> !stat_o);
  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o.enable |-> !pend_o);
endmodule

// File: rtl/icu_arb.sv
module icu_arb #(
  parameter int unsigned N  = 64,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          rot_i,
  input  logic [IW-1:0] ptr_i,
  output logic          any_o,
  output logic [IW-1:0] win_o
);
  logic [IW-1:0] start, idx;

  // N is a power of two, so IW-bit sums wrap around the ring
  always_comb begin
    any_o = 1'b0;
    win_o = IW'(N - 1);
    idx   = '0;
    start = rot_i ? ptr_i + 1'b1 : '0;
    for (int k = 0; k < N; k++) begin
      idx = start + IW'(k);
      if (!any_o && req_i[idx]) begin
        any_o = 1'b1;
        win_o = idx;
      end
    end
  end

  a_r8_win_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> req_i[win_o]);
  a_r8_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i == '0) |-> (!any_o && win_o == IW'(N - 1)));
  a_r8_fixed_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_o && !rot_i) |-> ((req_i & ((N'(1) << win_o) - N'(1))) == '0));
endmodule

// File: rtl/icu_vec64.sv
module icu_vec64
  import icu_pkg::*;
#(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned AW    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [3:0]       bus_be_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             irq_o,
  output logic             fiq_o,
  output logic [5:0]       aux_o
);
  localparam int unsigned IW         = $clog2(N_SRC);
  localparam int unsigned CTRL_WORDS = N_SRC / 4;
  localparam int unsigned STAT_WORDS = N_SRC / 32;
  localparam int unsigned NUM_ARB    = 2;

  logic wr, rd;
  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  src_ctrl_t          ctrl [N_SRC];
  logic [N_SRC-1:0]   stat, pend;

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    logic cwe, clr;
    assign cwe = wr && bus_addr_i == AW'(W_CTRL + n / 4) && bus_be_i[n % 4];
    assign clr = wr && bus_addr_i == AW'(W_STAT + n / 32) &&
                 bus_be_i[(n % 32) / 8] && bus_wdata_i[n % 32];
    icu_src u_src (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .src_i        (src_i[n]),
      .ctrl_we_i    (cwe),
      .ctrl_wdata_i (bus_wdata_i[8*(n%4) +: 8]),
      .clr_i        (clr),
      .ctrl_o       (ctrl[n]),
      .stat_o       (stat[n]),
      .pend_o       (pend[n])
    );
  end

  logic [NUM_DEST-1:0]             dest_req;
  logic [NUM_ARB-1:0][N_SRC-1:0]   arb_req;

  always_comb begin
    dest_req = '0;
    arb_req  = '0;
    for (int n = 0; n < N_SRC; n++) begin
      if (pend[n]) dest_req[ctrl[n].dest] = 1'b1;
      arb_req[0][n] = pend[n] && ctrl[n].dest == DST_IRQ;
      arb_req[1][n] = pend[n] && ctrl[n].dest == DST_FIQ;
    end
  end

  assign irq_o = dest_req[0];
  assign fiq_o = dest_req[1];
  assign aux_o = dest_req[NUM_DEST-1:2];

  logic [NUM_ARB-1:0]          rot_q, any;
  logic [NUM_ARB-1:0][IW-1:0]  ptr_q, win;

  for (genvar k = 0; k < NUM_ARB; k++) begin : g_arb
    logic id_rd, pri_wr;
    assign id_rd  = rd && bus_addr_i == AW'(W_ID + k);
    assign pri_wr = wr && bus_addr_i == AW'(W_PRI + k) && bus_be_i[0];

    icu_arb #(.N(N_SRC)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (arb_req[k]),
      .rot_i  (rot_q[k]),
      .ptr_i  (ptr_q[k]),
      .any_o  (any[k]),
      .win_o  (win[k])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rot_q[k] <= 1'b0;
        ptr_q[k] <= '1;
      end else if (pri_wr) begin
        rot_q[k] <= bus_wdata_i[ROT_BIT];
        ptr_q[k] <= bus_wdata_i[IW-1:0];
      end else if (id_rd && any[k]) begin
        ptr_q[k] <= win[k];  // serviced source drops to lowest
      end
    end

    a_r9_ptr_follows_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_rd && any[k]) |=> (ptr_q[k] == $past(win[k])));
    a_r10_idle_keeps_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (id_rd && !any[k]) |=> $stable(ptr_q[k]));
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < NUM_ARB; k++) begin
      if (bus_addr_i == AW'(W_ID + k))  bus_rdata_o[IW-1:0] = win[k];
      if (bus_addr_i == AW'(W_PRI + k)) begin
        bus_rdata_o[IW-1:0]   = ptr_q[k];
        bus_rdata_o[ROT_BIT]  = rot_q[k];
      end
    end
    for (int w = 0; w < CTRL_WORDS; w++)
      if (bus_addr_i == AW'(W_CTRL + w))
        for (int b = 0; b < 4; b++) bus_rdata_o[8*b +: 8] = ctrl[4*w + b];
    for (int w = 0; w < STAT_WORDS; w++)
      if (bus_addr_i == AW'(W_STAT + w)) bus_rdata_o = stat[32*w +: 32];
  end
endmodule

// File: tb/sim_icu_vec64.sv
module sim_icu_vec64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  logic [5:0]  aux;

  always #2 clk = ~clk;

  icu_vec64 u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_be_i(be),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq), .aux_o(aux)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [7:0]  m_ctrl [64];
  logic [63:0] m_stat = '0, m_src = '0;
  logic        m_rot [2];
  logic [5:0]  m_ptr [2];

  function automatic logic m_pend(int n);
    logic edg;
    edg = m_ctrl[n][5] | m_ctrl[n][6];
    return m_ctrl[n][3] && (edg ? m_stat[n] : m_src[n]);
  endfunction

  function automatic logic [7:0] m_dest();
    logic [7:0] d;
    d = '0;
    for (int n = 0; n < 64; n++) if (m_pend(n)) d[m_ctrl[n][2:0]] = 1'b1;
    return d;
  endfunction

  function automatic logic [6:0] m_win(int k);
    logic [5:0] st, idx;
    st = m_rot[k] ? m_ptr[k] + 6'd1 : 6'd0;
    for (int j = 0; j < 64; j++) begin
      idx = st + 6'(j);
      if (m_pend(idx) && m_ctrl[idx][2:0] == 3'(k)) return {1'b1, idx};
    end
    return {1'b0, 6'd63};
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    logic [31:0] r;
    logic [6:0]  w;
    r = '0;
    if (a == 6'h00 || a == 6'h01) begin w = m_win(a); r[5:0] = w[5:0]; end
    else if (a == 6'h08 || a == 6'h09) r = {25'd0, m_rot[a-8], m_ptr[a-8]};
    else if (a >= 6'h10 && a <= 6'h1F)
      for (int b = 0; b < 4; b++) r[8*b +: 8] = m_ctrl[(a-6'h10)*4 + b];
    else if (a == 6'h20) r = m_stat[31:0];
    else if (a == 6'h21) r = m_stat[63:32];
    return r;
  endfunction

  task automatic check(bit ok, string r, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(logic [63:0] ns, bit w, logic [5:0] a, logic [3:0] b, logic [31:0] d);
    logic hit, clr;
    @(negedge clk);
    src = ns; req = w; we = w; addr = a; be = b; wdata = d;
    @(posedge clk);
    for (int n = 0; n < 64; n++) begin
      hit = (m_ctrl[n][5] && ns[n] && !m_src[n]) || (m_ctrl[n][6] && !ns[n] && m_src[n]);
      clr = w && a == 6'(6'h20 + n/32) && b[(n%32)/8] && d[n%32];
      m_stat[n] = (m_stat[n] && !clr) || hit;
    end
    if (w) begin
      for (int n = 0; n < 64; n++)
        if (a == 6'(6'h10 + n/4) && b[n%4]) m_ctrl[n] = d[8*(n%4) +: 8];
      for (int k = 0; k < 2; k++)
        if (a == 6'(8 + k) && b[0]) begin m_rot[k] = d[6]; m_ptr[k] = d[5:0]; end
    end
    m_src = ns;
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [3:0] b, logic [31:0] d);
    cyc(m_src, 1'b1, a, b, d);
  endtask

  task automatic set_src(logic [63:0] ns);
    cyc(ns, 1'b0, 6'd0, 4'd0, 32'd0);
  endtask

  task automatic rd(logic [5:0] a, string r);
    logic [31:0] e;
    logic [6:0]  w;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 e = m_read(a);
    check(rdata == e, r, rdata, e);
    @(posedge clk);
    if (a <= 6'h01) begin
      w = m_win(a);
      if (w[6]) m_ptr[a] = w[5:0];
    end
    #1 req = 1'b0;
  endtask

  task automatic chk_io(string r);
    logic [7:0] e;
    e = m_dest();
    check({aux, fiq, irq} == e, r, {aux, fiq, irq}, e);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int n = 0; n < 64; n++) m_ctrl[n] = '0;
    m_rot[0] = 0; m_rot[1] = 0; m_ptr[0] = 6'd63; m_ptr[1] = 6'd63;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    #1 check({aux, fiq, irq} == 8'd0, "R1 outputs", {aux, fiq, irq}, 0);
    rd(6'h00, "R1 id irq"); rd(6'h01, "R1 id fiq");
    rd(6'h08, "R1 pri"); rd(6'h09, "R1 pri fiq");
    rd(6'h10, "R1 ctrl"); rd(6'h21, "R1 stat");

    // R2 byte-lane control writes
    wr(6'h10, 4'b0101, 32'hAABB_CCDD);
    rd(6'h10, "R2 lanes");
    wr(6'h10, 4'hF, 32'h0); wr(6'h20, 4'hF, 32'hFFFF_FFFF);
    rd(6'h10, "R2 cleared");

    // R3 level mode, source 5 to irq
    wr(6'h11, 4'b0010, 32'h0000_0800);
    set_src(64'd1 << 5); chk_io("R3 level high"); rd(6'h00, "R3 id");
    set_src(64'd0); chk_io("R3 level low");

    // R7 disabled source
    wr(6'h11, 4'b0010, 32'h0000_2000);
    set_src(64'd1 << 5); chk_io("R7 disabled edge"); rd(6'h20, "R4 latch while disabled");
    rd(6'h00, "R7 id");
    wr(6'h20, 4'hF, 32'hFFFF_FFFF); wr(6'h11, 4'hF, 32'h0); set_src(64'd0);

    // R4 edge latching, 40 rising to fiq, 41 falling to fiq
    wr(6'h1A, 4'b0011, 32'h0000_4929);
    set_src(64'd1 << 40); chk_io("R4 rise"); rd(6'h21, "R4 stat rise"); rd(6'h01, "R4 fiq id");
    set_src(64'd1 << 41); chk_io("R4 held"); rd(6'h21, "R4 rise of falling src");
    set_src(64'd0); rd(6'h21, "R4 fall"); chk_io("R4 fall out");

    // R5 write-one-to-clear
    wr(6'h21, 4'b0010, 32'h0000_0100); rd(6'h21, "R5 clear bit40");
    wr(6'h21, 4'b0001, 32'h0000_0200); rd(6'h21, "R5 lane off");
    set_src(64'd1 << 41);
    wr(6'h21, 4'b0010, 32'h0000_0200);
    cyc(64'd0, 1'b1, 6'h21, 4'b0010, 32'h0000_0200);
    rd(6'h21, "R5 edge beats clear"); chk_io("R5 out");
    wr(6'h21, 4'hF, 32'hFFFF_FFFF); wr(6'h1A, 4'hF, 32'h0); rd(6'h21, "R5 all clear");

    // R6 destinations, sources 16..23 level
    wr(6'h14, 4'hF, 32'h0B0A_0908); wr(6'h15, 4'hF, 32'h0F0E_0D0C);
    for (int d = 0; d < 8; d++) begin
      set_src(64'd1 << (16 + d)); chk_io("R6 dest");
    end
    set_src(64'd0);

    // R8 fixed priority
    wr(6'h13, 4'b0001, 32'h08); wr(6'h17, 4'b0100, 32'h0008_0000);
    wr(6'h1C, 4'b0100, 32'h0008_0000);
    wr(6'h1B, 4'b0001, 32'h09); wr(6'h12, 4'b0010, 32'h0900);
    set_src((64'd1 << 12) | (64'd1 << 30) | (64'd1 << 50) | (64'd1 << 44) | (64'd1 << 9));
    rd(6'h00, "R8 irq lowest"); rd(6'h00, "R8 fixed repeat"); rd(6'h01, "R8 fiq lowest");
    chk_io("R8 out");

    // R9 rotating
    wr(6'h08, 4'b0001, 32'h0000_007E); rd(6'h08, "R9 pri write");
    for (int i = 0; i < 4; i++) rd(6'h00, "R9 rotate irq");
    rd(6'h08, "R9 ptr");
    wr(6'h09, 4'b0001, 32'h0000_007F);
    for (int i = 0; i < 3; i++) rd(6'h01, "R9 rotate fiq");

    // R10 idle vs source 63
    set_src(64'd0);
    rd(6'h00, "R10 idle"); rd(6'h08, "R10 ptr kept"); rd(6'h21, "R10 bit31 idle");
    wr(6'h1F, 4'b1000, 32'h2800_0000);
    set_src(64'd1 << 63);
    rd(6'h21, "R10 bit31 set"); rd(6'h00, "R10 src63"); rd(6'h08, "R10 ptr63");
    wr(6'h08, 4'b0001, 32'h3F);

    // mixed random traffic
    for (int it = 0; it < 600; it++) begin
      int op, n;
      logic [5:0] a;
      op = $urandom_range(0, 6);
      case (op)
        0: set_src(m_src ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}));
        1, 2: begin
          n = $urandom_range(0, 63);
          wr(6'(6'h10 + n/4), 4'(1 << (n%4)), 32'($urandom_range(0, 255)) << (8*(n%4)));
        end
        3: wr(6'(6'h20 + $urandom_range(0, 1)), 4'($urandom), $urandom);
        4: rd(6'($urandom_range(0, 1)), "R9 random id");
        5: wr(6'(8 + $urandom_range(0, 1)), 4'hF, 32'($urandom_range(0, 127)));
        default: begin
          a = 6'($urandom_range(0, 3));
          a = (a == 0) ? 6'h08 : (a == 1) ? 6'h09 : (a == 2) ? 6'h20 : 6'h21;
          rd(a, "R4 random regs");
        end
      endcase
      chk_io("R6 random outputs");
    end
    report();
  end
endmodule